// File: doc/BRIEF.md
# Coherent Store Buffer with Load Forwarding

This block sits between a core's load/store unit and its private data cache in a coherent multicore. The core hands it stores without waiting for ownership of the target line. A store to a line the core does not hold writable is placed in a small circular buffer, and an invalidate carrying the line address and the entry's slot number goes out to the peer cores. Each peer answers with an acknowledge tagged with that slot number. An entry may be written into the cache only when its peers have all answered. Entries leave the buffer strictly in program order. A store to a line the core already holds writable still passes through the buffer, which keeps the order intact, but it does not wait for any acknowledge.

Loads check the buffer before the cache. When one or more live entries match the load address, the youngest of them supplies the data and the cache word is ignored. Buffered data stays private to the core. It leaves the block only through the forwarded load result and the cache write port, and the invalidate port carries only an address and a slot number. A write barrier holds off new stores until every entry has been committed, and then reports completion.

Top module: `sbuf_top`

## Requirements
- R1: A store to a line not held writable (`st_owned`=0) is accepted whenever the buffer is not full and no barrier is requested. In the cycle after acceptance, `inv_valid` is high with `inv_addr` equal to the store address and `inv_tag` equal to the entry's slot. Slots are handed out round-robin, starting at 0 after reset, one per accepted store. Invalidates go out in program order, and each holds its values until `inv_ready` is seen.
- R2: An entry that needs acknowledges is written to the cache only after PEERS acknowledges carrying its slot number on `ack_tag` have arrived. If the entry is the oldest, `cw_valid` rises in the cycle after the last of these acknowledges.
- R3: `ld_hit` and `ld_data` respond to `ld_addr` in the same cycle. On a match with a live entry, `ld_hit`=1 and `ld_data` is that entry's data. Otherwise `ld_hit`=0 and `ld_data` equals `ld_cache_data`.
- R4: While `bar_req` is high, `st_ready` is low. `bar_done` is high in the cycle after a cycle in which `bar_req` was high and the buffer was empty. It is never high while entries remain.
- R5: Commits on the cache port (`cw_valid`, `cw_addr`, `cw_data`) follow program order. An entry with all its acknowledges waits behind any older entry that lacks them.
- R6: When several live entries match a load address, the youngest one supplies `ld_data`.
- R7: When DEPTH entries are held, `st_ready` is low and a store offered then is dropped. It never forwards and never commits.
- R8: A store with `st_owned`=1 raises no invalidate. If it is the oldest entry, it appears on the cache port in the cycle after acceptance, with no acknowledge needed.
- R9: After reset, `st_ready`=1, and `cw_valid`, `inv_valid`, `ld_hit` and `bar_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store accepted this cycle when high |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_owned | input | 1 | Line already held writable |
| ld_addr | input | ADDR_W | Load word address |
| ld_cache_data | input | DATA_W | Word read from the cache for the load |
| ld_hit | output | 1 | Load matched a buffered store |
| ld_data | output | DATA_W | Load result |
| inv_valid | output | 1 | Invalidate request pending |
| inv_ready | input | 1 | Invalidate taken by the coherence fabric |
| inv_addr | output | ADDR_W | Line address to invalidate in peers |
| inv_tag | output | TAG_W | Slot of the entry behind the invalidate |
| ack_valid | input | 1 | One peer acknowledge arrives |
| ack_tag | input | TAG_W | Slot the acknowledge belongs to |
| cw_valid | output | 1 | Cache write of the oldest entry |
| cw_addr | output | ADDR_W | Cache write address |
| cw_data | output | DATA_W | Cache write data |
| bar_req | input | 1 | Write barrier requested |
| bar_done | output | 1 | Barrier complete, buffer drained |

## Verification
The bench builds the block with DEPTH=4, PEERS=2, ADDR_W=8 and DATA_W=16. With only four slots the buffer fills after a few stores, so the refused store, slot wrap-around and out-of-order acknowledges of a full buffer are all reached quickly. Two peers are enough to check that a single acknowledge does not release an entry. A sweep over a window of load addresses, with duplicate addresses in the buffer, exercises both the youngest-match choice and the cache fallback. A run of sixteen stores that mixes writable-held and unheld lines wraps the slot pointer four times.

// File: rtl/sbuf_pkg.sv
// Shared types and helpers for the store buffer.
// Assumes nothing beyond standard SystemVerilog.
package sbuf_pkg;

    // Per-entry state bits.
    typedef struct packed {
        logic live;   // entry holds an uncommitted store
        logic sent;   // invalidate issued (or not needed)
        logic owned;  // line was writable at acceptance
    } sb_flag_t;

    // Width of a slot index for a buffer of the given depth.
    function automatic int ptr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/sbuf_ack_ctr.sv
// Acknowledge counter for one buffer entry.
// Counts peer acknowledges from allocation until PEERS have arrived.
// Assumes a peer acknowledges an entry at most once per invalidate.
module sbuf_ack_ctr #(
    parameter int PEERS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam int CNT_W = $clog2(PEERS + 1);
    localparam logic [CNT_W-1:0] NEED = CNT_W'(PEERS);

    logic [CNT_W-1:0] cnt_q;

    // Restart on allocation, step once per tagged acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == NEED);

    // R2: never more acknowledges than peers
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= NEED);

    // R2: an entry never receives an acknowledge beyond its peers
    p_no_extra_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> !done);

endmodule

// File: rtl/sbuf_fwd.sv
// Load forwarding lookup over the buffer entries.
// Walks the entries from oldest to youngest so the last match wins.
// Assumes DEPTH is a power of two (slot indices wrap naturally).
module sbuf_fwd #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int PTR_W  = 2
) (
    input  logic              ent_live [DEPTH],
    input  logic [ADDR_W-1:0] ent_addr [DEPTH],
    input  logic [DATA_W-1:0] ent_data [DEPTH],
    input  logic [PTR_W-1:0]  head_idx,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_cache_data,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data
);
    // Youngest live match supplies data, otherwise the cache word passes.
    always_comb begin
        logic [PTR_W-1:0]  idx;
        logic              hit;
        logic [DATA_W-1:0] fwd;
        hit = 1'b0;
        fwd = '0;
        idx = head_idx;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_idx + PTR_W'(k);
            if (ent_live[idx] && (ent_addr[idx] == ld_addr)) begin
                hit = 1'b1;
                fwd = ent_data[idx];
            end
        end
        ld_hit  = hit;
        ld_data = hit ? fwd : ld_cache_data;
    end

endmodule

// File: rtl/sbuf_issue.sv
// Invalidate issue walker.
// Visits entries in program order. It sends an invalidate for each entry
// not yet sent and skips entries that need none. Assumes the top commits
// an entry only after it has been marked sent.
module sbuf_issue #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4,
    parameter int PTR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W:0]    tail_ptr,
    input  logic              ent_live [DEPTH],
    input  logic              ent_sent [DEPTH],
    input  logic [ADDR_W-1:0] ent_addr [DEPTH],
    input  logic              inv_ready,
    output logic              inv_valid,
    output logic [ADDR_W-1:0] inv_addr,
    output logic [PTR_W-1:0]  inv_tag,
    output logic              mark_sent
);
    logic [PTR_W:0]   iss_q;
    logic [PTR_W-1:0] idx;
    logic             ahead;
    logic             adv;

    // Decode the entry under the walker.
    always_comb begin
        idx       = iss_q[PTR_W-1:0];
        ahead     = (iss_q != tail_ptr);
        inv_valid = ahead && ent_live[idx] && !ent_sent[idx];
        inv_addr  = ent_addr[idx];
        inv_tag   = idx;
        mark_sent = inv_valid && inv_ready;
        adv       = ahead && ent_live[idx] && (ent_sent[idx] || inv_ready);
    end

    // Move past an entry once its invalidate is out or not needed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_q <= '0;
        end else if (adv) begin
            iss_q <= iss_q + 1'b1;
        end
    end

    // R1: the walker never points at a committed entry
    p_ahead_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ahead |-> ent_live[idx]);

    // R1: a pending invalidate holds its values until taken
    p_inv_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_addr) && $stable(inv_tag)));

endmodule

// File: rtl/sbuf_top.sv
// Per-core store buffer with forwarding and acknowledge-gated commit.
// Stores enter a circular buffer of DEPTH slots. Entries for lines not
// held writable wait for PEERS tagged acknowledges, and entries commit to
// the cache in program order. A write barrier blocks new stores until
// the buffer drains. Assumes DEPTH is a power of two and that the cache
// write port accepts a write every cycle.
module sbuf_top
    import sbuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int PEERS  = 3,
    localparam int TAG_W = ptr_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              st_owned,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_cache_data,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic              inv_valid,
    input  logic              inv_ready,
    output logic [ADDR_W-1:0] inv_addr,
    output logic [TAG_W-1:0]  inv_tag,
    input  logic              ack_valid,
    input  logic [TAG_W-1:0]  ack_tag,
    output logic              cw_valid,
    output logic [ADDR_W-1:0] cw_addr,
    output logic [DATA_W-1:0] cw_data,
    input  logic              bar_req,
    output logic              bar_done
);
    localparam int PTR_W = TAG_W;
    localparam logic [PTR_W:0] FULL_OCC = (PTR_W + 1)'(DEPTH);

    logic [PTR_W:0]    head_q;
    logic [PTR_W:0]    tail_q;
    logic [PTR_W:0]    occ;
    logic [PTR_W-1:0]  head_idx;
    logic [PTR_W-1:0]  tail_idx;
    logic              full;
    logic              alloc;
    logic              commit;
    logic              mark_sent;
    logic              bar_done_q;

    logic              live_v  [DEPTH];
    logic              sent_v  [DEPTH];
    logic              owned_v [DEPTH];
    logic              ack_done[DEPTH];
    logic [ADDR_W-1:0] addr_v  [DEPTH];
    logic [DATA_W-1:0] data_v  [DEPTH];

    // Occupancy, acceptance and commit decisions.
    always_comb begin
        head_idx = head_q[PTR_W-1:0];
        tail_idx = tail_q[PTR_W-1:0];
        occ      = tail_q - head_q;
        full     = (occ == FULL_OCC);
        st_ready = !full && !bar_req;
        alloc    = st_valid && st_ready;
        commit   = live_v[head_idx] && sent_v[head_idx]
                   && (owned_v[head_idx] || ack_done[head_idx]);
    end

    // Head and tail pointers of the circular buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (alloc)  tail_q <= tail_q + 1'b1;
            if (commit) head_q <= head_q + 1'b1;
        end
    end

    // One storage slot per entry, each with its own acknowledge counter.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam logic [PTR_W-1:0] SLOT = PTR_W'(g);
        sb_flag_t          flag_q;
        logic [ADDR_W-1:0] addr_q;
        logic [DATA_W-1:0] data_q;

        // Entry flags: set on allocation, sent on issue, freed on commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= '0;
            end else if (alloc && (tail_idx == SLOT)) begin
                flag_q.live  <= 1'b1;
                flag_q.sent  <= st_owned;
                flag_q.owned <= st_owned;
            end else begin
                if (mark_sent && (inv_tag == SLOT)) flag_q.sent <= 1'b1;
                if (commit && (head_idx == SLOT))   flag_q.live <= 1'b0;
            end
        end

        // Payload capture; contents are only read while the entry is live.
        always_ff @(posedge clk) begin
            if (alloc && (tail_idx == SLOT)) begin
                addr_q <= st_addr;
                data_q <= st_data;
            end
        end

        sbuf_ack_ctr #(.PEERS(PEERS)) u_ack (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (alloc && (tail_idx == SLOT)),
            .inc  (ack_valid && (ack_tag == SLOT)),
            .done (ack_done[g])
        );

        assign live_v[g]  = flag_q.live;
        assign sent_v[g]  = flag_q.sent;
        assign owned_v[g] = flag_q.owned;
        assign addr_v[g]  = addr_q;
        assign data_v[g]  = data_q;
    end

    sbuf_fwd #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_fwd (
        .ent_live     (live_v),
        .ent_addr     (addr_v),
        .ent_data     (data_v),
        .head_idx     (head_idx),
        .ld_addr      (ld_addr),
        .ld_cache_data(ld_cache_data),
        .ld_hit       (ld_hit),
        .ld_data      (ld_data)
    );

    sbuf_issue #(
        .ADDR_W(ADDR_W),
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_iss (
        .clk      (clk),
        .rst_n    (rst_n),
        .tail_ptr (tail_q),
        .ent_live (live_v),
        .ent_sent (sent_v),
        .ent_addr (addr_v),
        .inv_ready(inv_ready),
        .inv_valid(inv_valid),
        .inv_addr (inv_addr),
        .inv_tag  (inv_tag),
        .mark_sent(mark_sent)
    );

    // Barrier completes one cycle after it is seen with an empty buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bar_done_q <= 1'b0;
        end else begin
            bar_done_q <= bar_req && (occ == '0);
        end
    end

    assign bar_done = bar_done_q;
    assign cw_valid = commit;
    assign cw_addr  = addr_v[head_idx];
    assign cw_data  = data_v[head_idx];

    // R7: occupancy never exceeds the buffer depth
    p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_OCC);

    // R4: barrier done only with nothing left to commit
    p_bar_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bar_done |-> ((occ == '0) && !cw_valid));

    // R3: a forwarding hit needs a buffered entry
    p_hit_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit |-> (occ != '0));

endmodule

// File: tb/sbuf_top_test.sv
module sbuf_top_test;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int DP = 4;
    localparam int NP = 2;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic          st_ready;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_owned = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_cache_data = '0;
    logic          ld_hit;
    logic [DW-1:0] ld_data;
    logic          inv_valid;
    logic          inv_ready = 1'b1;
    logic [AW-1:0] inv_addr;
    logic [TW-1:0] inv_tag;
    logic          ack_valid = 1'b0;
    logic [TW-1:0] ack_tag = '0;
    logic          cw_valid;
    logic [AW-1:0] cw_addr;
    logic [DW-1:0] cw_data;
    logic          bar_req = 1'b0;
    logic          bar_done;

    sbuf_top #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP), .PEERS(NP)) uut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_owned(st_owned),
        .ld_addr(ld_addr), .ld_cache_data(ld_cache_data),
        .ld_hit(ld_hit), .ld_data(ld_data),
        .inv_valid(inv_valid), .inv_ready(inv_ready),
        .inv_addr(inv_addr), .inv_tag(inv_tag),
        .ack_valid(ack_valid), .ack_tag(ack_tag),
        .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_data(cw_data),
        .bar_req(bar_req), .bar_done(bar_done)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    logic [AW-1:0] log_a [64];
    logic [DW-1:0] log_d [64];
    int n_log = 0;
    logic [AW-1:0] ilog_a [64];
    logic [TW-1:0] ilog_t [64];
    int n_ilog = 0;

    // Bench-side model of the entries in program order
    logic [AW-1:0] m_a [DP];
    logic [DW-1:0] m_d [DP];
    int m_n = 0;
    int slot = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic end_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Logs of commits and taken invalidates, sampled mid low phase
    always @(negedge clk) begin
        #3;
        if (rst_n && cw_valid && n_log < 64) begin
            log_a[n_log] = cw_addr;
            log_d[n_log] = cw_data;
            n_log++;
        end
        if (rst_n && inv_valid && inv_ready && n_ilog < 64) begin
            ilog_a[n_ilog] = inv_addr;
            ilog_t[n_ilog] = inv_tag;
            n_ilog++;
        end
    end

    task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic o);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_owned = o;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic ack(input int t);
        @(negedge clk);
        ack_valid = 1'b1; ack_tag = TW'(t);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic wait_log(input int want);
        int tries = 0;
        while (n_log < want && tries < 8) begin
            @(negedge clk); #5;
            tries++;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog act=hung exp=finish");
        end_run();
    end

    initial begin
        int n_unowned;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R9: reset state
        chk("R9 st_ready", int'(st_ready), 1);
        chk("R9 cw_valid", int'(cw_valid), 0);
        chk("R9 inv_valid", int'(inv_valid), 0);
        chk("R9 bar_done", int'(bar_done), 0);
        ld_addr = 8'h10; ld_cache_data = 16'hC0DE; #1;
        chk("R9 ld_hit", int'(ld_hit), 0);
        chk("R3 cache pass", int'(ld_data), 16'hC0DE);

        // R8: owned store commits next cycle, no invalidate
        store(8'h10, 16'hAAAA, 1'b1); slot++;
        #5;
        chk("R8 cw_valid", int'(cw_valid), 1);
        chk("R8 cw_addr", int'(cw_addr), 8'h10);
        chk("R8 cw_data", int'(cw_data), 16'hAAAA);
        chk("R8 no inv", int'(inv_valid), 0);
        @(negedge clk); #5;
        chk("R8 one commit", n_log, 1);

        // R1/R2: unowned store needs both acknowledges
        store(8'h20, 16'h1234, 1'b0);
        #5;
        chk("R1 inv_valid", int'(inv_valid), 1);
        chk("R1 inv_addr", int'(inv_addr), 8'h20);
        chk("R1 inv_tag", int'(inv_tag), slot);
        chk("R2 no early commit", int'(cw_valid), 0);
        ack(slot); #5;
        chk("R2 one ack not enough", int'(cw_valid), 0);
        ack(slot); #5;
        chk("R2 commit after acks", int'(cw_valid), 1);
        chk("R2 cw_addr", int'(cw_addr), 8'h20);
        chk("R2 cw_data", int'(cw_data), 16'h1234);
        slot++;
        @(negedge clk); #5;
        chk("R2 commit once", n_log, 2);

        // R7/R3/R6: fill the buffer with a duplicate address
        m_a[0] = 8'h30; m_d[0] = 16'h1111;
        m_a[1] = 8'h31; m_d[1] = 16'h2222;
        m_a[2] = 8'h30; m_d[2] = 16'h3333;
        m_a[3] = 8'h32; m_d[3] = 16'h4444;
        for (int j = 0; j < DP; j++) store(m_a[j], m_d[j], 1'b0);
        m_n = DP;
        #5;
        chk("R7 full not ready", int'(st_ready), 0);
        store(8'h3F, 16'h9999, 1'b0);
        for (int a = 8'h2E; a <= 8'h3F; a++) begin
            logic eh;
            logic [DW-1:0] ed;
            @(negedge clk);
            ld_addr = AW'(a);
            ld_cache_data = DW'(a * 16'h0101) ^ 16'h5A5A;
            eh = 1'b0; ed = ld_cache_data;
            for (int j = 0; j < m_n; j++)
                if (m_a[j] == AW'(a)) begin eh = 1'b1; ed = m_d[j]; end
            #5;
            chk("R3 ld_hit", int'(ld_hit), int'(eh));
            chk("R6 ld_data", int'(ld_data), int'(ed));
        end
        chk("R7 dropped store no commit", n_log, 2);
        chk("R1 inv count", n_ilog, 5);
        for (int j = 0; j < DP; j++) begin
            chk("R1 inv order tag", int'(ilog_t[1+j]), (slot + j) % DP);
            chk("R1 inv order addr", int'(ilog_a[1+j]), int'(m_a[j]));
        end

        // R5/R4: out-of-order acknowledges under a barrier
        @(negedge clk);
        bar_req = 1'b1; #5;
        chk("R4 stores blocked", int'(st_ready), 0);
        chk("R4 not done yet", int'(bar_done), 0);
        ack((slot + 3) % DP); ack((slot + 3) % DP);
        ack((slot + 2) % DP); ack((slot + 2) % DP);
        ack((slot + 1) % DP); ack((slot + 1) % DP);
        repeat (2) @(negedge clk);
        #5;
        chk("R5 younger waits", n_log, 2);
        chk("R4 not done with entries", int'(bar_done), 0);
        ack(slot); ack(slot);
        begin
            int tries = 0;
            #5;
            while (!bar_done && tries < 10) begin
                @(negedge clk); #5;
                tries++;
            end
        end
        chk("R4 bar_done", int'(bar_done), 1);
        chk("R4 drained", n_log, 6);
        for (int j = 0; j < DP; j++) begin
            chk("R5 order addr", int'(log_a[2+j]), int'(m_a[j]));
            chk("R5 order data", int'(log_d[2+j]), int'(m_d[j]));
        end
        slot = (slot + DP) % DP;
        m_n = 0;
        @(negedge clk);
        bar_req = 1'b0;

        // R5/R8/R2: mixed sweep wrapping the slot pointer
        n_unowned = 0;
        for (int k = 0; k < 16; k++) begin
            logic o;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            o = (k % 3 == 0);
            a = AW'(8'h40 + k);
            d = DW'(k * 16'h1357);
            store(a, d, o);
            if (!o) begin
                ack(slot); ack(slot);
                n_unowned++;
            end
            slot = (slot + 1) % DP;
            #5;
            wait_log(7 + k);
            chk("R5 sweep count", n_log, 7 + k);
            chk("R5 sweep addr", int'(log_a[6+k]), int'(a));
            chk("R2 sweep data", int'(log_d[6+k]), int'(d));
        end
        chk("R8 inv only unowned", n_ilog, 5 + n_unowned);
        end_run();
    end

endmodule